// File: doc/BRIEF.md
# Prioritized Eight-Source Interrupt Controller

This block is the interrupt front end of a small 8-bit processor core. It watches eight request sources: three vectored restart lines (levels 5.5, 6.5 and 7.5), four extra restart lines (levels 1.5 to 4.5) that share a status byte with serial inputs, and one general request line whose vector comes from an 8-bit input register. Every input passes through a two-flop synchronizer. The synchronized lines are then gated by a mask register and a global enable, and a fixed-priority encoder picks the winner.

The core writes the mask register and reads it back through an 8-bit accumulator-style port. Requests are taken only when the core raises its fetch strobe, or on every clock while the core is halted. When a request is taken, the block emits a one-cycle take pulse and a 16-bit restart address, clears the global enable and leaves halt. The core pushes the return address (the instruction after the halt, when halted) and loads the program counter itself.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), take_o and halted_o are 0, the global enable is 0, the three low mask bits are 0 and the four extra-line enable bits are 0, so mask_rdata_o[3:0] reads 0000.
- R2: A mask write (mask_wr_i high at an edge) with data bit 0, 1 or 2 set to 1 masks level 5.5, 6.5 or 7.5 respectively; a masked line is never taken, and with the bit at 0 it is taken.
- R3: Mask write data bit 3 sets the global enable (1 enables, 0 disables). While disabled no request is taken, and the read port still shows the live lines.
- R4: Mask write data bits 7, 6, 5 and 4 enable the extra lines 4.5, 3.5, 2.5 and 1.5 respectively when 1 (opposite sense to bits 2:0); after reset all four are disabled.
- R5: mask_rdata_o is {INTR, level 7.5, level 6.5, level 5.5, enable, mask bit 2, mask bit 1, mask bit 0}, high nibble taken from the synchronized lines.
- R6: Among enabled pending requests the winner is the highest level: 7.5, 6.5, 5.5, 4.5, 3.5, 2.5, 1.5, then INTR last.
- R7: Level n.5 produces vec_o = n*8+4 (0x000C for 1.5 up to 0x003C for 7.5); INTR produces vec_o = {8'h00, intr_vec_i}. INTR has no individual mask.
- R8: Requests are evaluated only in a cycle with fetch_i high (or while halted); take_o is a one-cycle pulse in the cycle after that strobe edge, with vec_o valid alongside it.
- R9: halt_i high at an edge sets halted_o; while halted the block evaluates every clock, stays halted with no enabled request, and clears halted_o at the edge that raises take_o.
- R10: Taking a request clears the global enable, so mask_rdata_o[3] reads 0 after take_o.
- R11: Each input passes through two flops: a change is not visible at the read port after one clock edge and is visible after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_lines_i | input | 3 | Restart lines: bit0 level 5.5, bit1 6.5, bit2 7.5 |
| ext_lines_i | input | 4 | Extra lines: bit0 level 1.5 ... bit3 level 4.5 |
| intr_i | input | 1 | General request line |
| intr_vec_i | input | 8 | Low address byte used for the general request |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| mask_rdata_o | output | 8 | Mask and line status read data |
| fetch_i | input | 1 | Instruction-fetch strobe |
| halt_i | input | 1 | Enter halt-wait mode |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| vec_o | output | 16 | Restart address for the taken request |
| halted_o | output | 1 | Halt-wait mode active |

## Verification
On every cycle the assertions check that a take happens only with the enable set and right after a fetch strobe or a halted cycle, that it leaves the enable clear, that the encoder grants at most one source and only a pending one, and that halt is left only through a take. The choice of the winner, the vector values, the mask polarities of both nibbles and the synchronizer delay are shown only by the bench's scenarios, chiefly a sweep of all 256 request patterns against sixteen mask settings.

// File: rtl/irq_pkg.sv
// Package: shared sizes and the vector computation for the interrupt controller.
// Assumes request index k (1..7) is restart level k.5 and index 0 is INTR.
package irq_pkg;
    parameter int NUM_SRC   = 8;
    parameter int VEC_W     = 16;
    parameter int IDX_W     = $clog2(NUM_SRC);

    // Low address byte of restart level k.5: k*8+4.
    function automatic logic [7:0] level_vector(input logic [IDX_W-1:0] idx);
        return {2'b00, idx, 3'b100};
    endfunction
endpackage

// File: rtl/irq_sync.sv
// Module: multi-stage synchronizer for asynchronous request lines.
// Assumes each bit is independent (no bus coherency needed).
module irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the inputs through the flop chain, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_mask_regs.sv
// Module: mask register and global enable; turns them into a per-source enable.
// Assumes take_i is a one-cycle pulse; a take overrides a same-cycle enable write.
module irq_mask_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    input  logic       take_i,
    output logic       ie_o,
    output logic [2:0] mlo_o,
    output logic [7:0] en_o
);
    logic       ie_q;
    logic [2:0] mlo_q;
    logic [3:0] mhi_q;

    // Mask bits load on write; enable loads on write and clears on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            mlo_q <= 3'b000;
            mhi_q <= 4'b0000;
        end else begin
            if (wr_i) begin
                mlo_q <= wdata_i[2:0];
                mhi_q <= wdata_i[7:4];
            end
            if (take_i)    ie_q <= 1'b0;
            else if (wr_i) ie_q <= wdata_i[3];
        end
    end

    // Low bits mask when set; high bits enable when set; INTR always enabled.
    always_comb begin
        en_o = ie_q ? {~mlo_q, mhi_q, 1'b1} : 8'h00;
    end

    assign ie_o  = ie_q;
    assign mlo_o = mlo_q;

    AST_TAKE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !ie_q);  // R10
endmodule

// File: rtl/irq_prio_enc.sv
// Module: fixed-priority encoder, highest index wins, combinational.
// Assumes index 0 (INTR) takes its vector from outside.
module irq_prio_enc
    import irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan upward so the highest pending index is left as the winner.
    always_comb begin
        idx_o   = '0;
        grant_o = '0;
        for (int k = 0; k < N; k++) begin
            if (req_i[k]) begin
                idx_o   = IDX_W'(k);
                grant_o = '0;
                grant_o[k] = 1'b1;
            end
        end
        any_o = |req_i;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));  // R6
    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);  // R6
    AST_GRANT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> $countones(grant_o) == 1);  // R6
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the prioritized interrupt controller.
// Assumes fetch_i and halt_i come from the core's sequencer; the core itself
// pushes the return address and loads vec_o into the program counter.
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  rst_lines_i,
    input  logic [3:0]  ext_lines_i,
    input  logic        intr_i,
    input  logic [7:0]  intr_vec_i,
    input  logic        mask_wr_i,
    input  logic [7:0]  mask_wdata_i,
    output logic [7:0]  mask_rdata_o,
    input  logic        fetch_i,
    input  logic        halt_i,
    output logic        take_o,
    output logic [15:0] vec_o,
    output logic        halted_o
);
    logic [NUM_SRC-1:0] line_s, en, req, grant;
    logic               ie, any, eval, take_d;
    logic [2:0]         mlo;
    logic [IDX_W-1:0]   idx;
    logic [7:0]         low_byte;
    logic               take_q, halted_q;
    logic [VEC_W-1:0]   vec_q;

    irq_sync #(.WIDTH(NUM_SRC), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({rst_lines_i, ext_lines_i, intr_i}),
        .sync_o(line_s)
    );

    irq_mask_regs u_mask (
        .clk(clk), .rst_n(rst_n), .wr_i(mask_wr_i), .wdata_i(mask_wdata_i),
        .take_i(take_d), .ie_o(ie), .mlo_o(mlo), .en_o(en)
    );

    assign req = line_s & en;

    irq_prio_enc #(.N(NUM_SRC)) u_enc (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .grant_o(grant), .any_o(any), .idx_o(idx)
    );

    // Decide whether this cycle evaluates and form the vector byte.
    always_comb begin
        eval     = fetch_i | halted_q;
        take_d   = eval & any;
        low_byte = (idx == '0) ? intr_vec_i : level_vector(idx);
    end

    // Register the take pulse, its vector and the halt-wait state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q   <= 1'b0;
            vec_q    <= '0;
            halted_q <= 1'b0;
        end else begin
            take_q <= take_d;
            if (take_d) vec_q <= {8'h00, low_byte};
            if (take_d)     halted_q <= 1'b0;
            else if (halt_i) halted_q <= 1'b1;
        end
    end

    assign take_o       = take_q;
    assign vec_o        = vec_q;
    assign halted_o     = halted_q;
    assign mask_rdata_o = {line_s[0], line_s[7:5], ie, mlo};

    AST_TAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(ie));  // R3
    AST_TAKE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(fetch_i || halted_o));  // R8
    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);  // R8
    AST_HALT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted_o) |-> take_o);  // R9
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rst_lines = '0;
    logic [3:0]  ext_lines = '0;
    logic        intr = 1'b0;
    logic [7:0]  intr_vec = '0;
    logic        mask_wr = 1'b0;
    logic [7:0]  mask_wdata = '0;
    logic [7:0]  mask_rdata;
    logic        fetch = 1'b0;
    logic        halt = 1'b0;
    logic        take;
    logic [15:0] vec;
    logic        halted;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;  // 50 MHz

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .rst_lines_i(rst_lines), .ext_lines_i(ext_lines),
        .intr_i(intr), .intr_vec_i(intr_vec), .mask_wr_i(mask_wr),
        .mask_wdata_i(mask_wdata), .mask_rdata_o(mask_rdata), .fetch_i(fetch),
        .halt_i(halt), .take_o(take), .vec_o(vec), .halted_o(halted)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive request pattern: bit k = level k.5 for k>=1, bit0 = INTR.
    task automatic set_lines(input logic [7:0] p);
        rst_lines = p[7:5];
        ext_lines = p[4:1];
        intr      = p[0];
    endtask

    task automatic wr_mask(input logic [7:0] d);
        mask_wr = 1'b1; mask_wdata = d;
        step(1);
        mask_wr = 1'b0;
    endtask

    function automatic logic [7:0] enables(input logic [7:0] m);
        logic [7:0] e;
        e[0] = 1'b1;
        for (int k = 1; k <= 4; k++) e[k] = m[3+k];       // bit 4+j-1 enables level j.5
        for (int k = 5; k <= 7; k++) e[k] = !m[k-5];     // bit k-5 masks level k.5
        return m[3] ? e : 8'h00;
    endfunction

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            report();
        end
    end

    initial begin
        step(3);
        // R1 reset state
        chk("R1 take", take, 0);
        chk("R1 halted", halted, 0);
        chk("R1 rdata low", mask_rdata[3:0], 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 rdata after release", mask_rdata, 0);

        // R4 extra lines masked after reset, even with enable on
        wr_mask(8'h08);
        set_lines(8'h1E);
        step(2);
        fetch = 1'b1; step(1); fetch = 1'b0;
        chk("R4 extra lines masked at reset", take, 0);

        // R11 synchronizer depth, R5 read layout
        set_lines(8'h00); step(3);
        wr_mask(8'h05);
        set_lines(8'hE1);
        @(posedge clk); #1;
        chk("R11 not visible after one edge", mask_rdata[7:4], 0);
        @(posedge clk); #1;
        chk("R11 visible after two edges", mask_rdata[7:4], 4'hF);
        step(1);
        chk("R5 read layout", mask_rdata, 8'hF5);

        // R3 disabled: no take, read still live
        wr_mask(8'h00);
        fetch = 1'b1; step(1); fetch = 1'b0;
        chk("R3 no take when disabled", take, 0);
        chk("R3 read while disabled", mask_rdata, 8'hF0);

        // R8 no evaluation without strobe
        wr_mask(8'h08);
        step(3);
        chk("R8 no take without fetch", take, 0);
        fetch = 1'b1; step(1); fetch = 1'b0;
        chk("R8 take after fetch", take, 1);
        chk("R7 level 7.5 vector", vec, 16'h003C);
        step(1);
        chk("R8 take is one cycle", take, 0);

        // R9 halt-wait
        set_lines(8'h00); step(3);
        wr_mask(8'h08);
        halt = 1'b1; step(1); halt = 1'b0;
        chk("R9 halted set", halted, 1);
        step(5);
        chk("R9 stays halted", halted, 1);
        chk("R9 no take while idle", take, 0);
        intr_vec = 8'h5A;
        set_lines(8'h01);
        step(2);
        chk("R9 no take before sync", take, 0);
        step(1);
        chk("R9 take while halted", take, 1);
        chk("R9 halt left", halted, 0);
        chk("R7 INTR vector", vec, 16'h005A);
        chk("R10 enable cleared", mask_rdata[3], 0);

        // Sweep: 16 mask settings x 256 request patterns (R2 R4 R6 R7 R10)
        for (int mi = 0; mi < 16; mi++) begin
            logic [7:0] m;
            m = {mi[3:0], 1'b1, mi[2:0] ^ mi[3:1]};
            for (int p = 0; p < 256; p++) begin
                logic [7:0] r;
                int win;
                logic [15:0] ev;
                set_lines(p[7:0]);
                intr_vec = p[7:0] ^ 8'hA5;
                wr_mask(m);
                step(1);
                fetch = 1'b1; step(1); fetch = 1'b0;
                r = p[7:0] & enables(m);
                win = -1;
                for (int k = 0; k < 8; k++) if (r[k]) win = k;
                if (win < 0) begin
                    chk("R2/R4 no enabled request", take, 0);
                    chk("R3 enable kept", mask_rdata[3], 1);
                end else begin
                    ev = (win == 0) ? {8'h00, intr_vec} : 16'(win * 8 + 4);
                    chk("R6 take", take, 1);
                    chk("R6/R7 vector", vec, ev);
                    chk("R10 enable cleared", mask_rdata[3], 0);
                end
            end
        end
        report();
    end
endmodule